// File: doc/BRIEF.md
# Snooping Three-State Invalidate Cache Controller

This block keeps one cache coherent with its peers on a shared snooping bus. It holds a small direct-mapped set of one-word lines. Each line is invalid, shared (clean, other caches may hold it too) or dirty (the only copy, changed locally). Processor reads and writes are served locally whenever the line state allows it. Otherwise the controller raises a bus request, holds the processor stalled, and completes one bus transaction when the grant comes.

It also watches the transactions that other caches put on the bus. A foreign read of a line held dirty makes the controller drive the line's data onto the bus and drop its copy to shared. A foreign invalidate, or a read with intent to modify, removes the local copy. Writes never update other caches. They invalidate them.

The bus command field uses these codes: 0 is a writeback, 1 is a read, 2 is a read with intent to modify, and 3 is an invalidate. A line address splits into its low log2(LINES) bits, which select the slot, and the remaining bits, which form the tag.

Top module: `snoop_coherence_ctrl`

## Requirements
- R1: After reset every line is invalid, `bus_req` and `snoop_flush` are low, and no access hits.
- R2: A read that misses raises `bus_req` with command 1 and the line address. In the grant cycle the line is filled from `bus_rdata` as shared. In the following cycle `cpu_ready` is high and `cpu_rdata` returns that data.
- R3: A read of a shared or dirty line, and a write to a dirty line, complete with `cpu_ready` high in the request cycle and no bus request.
- R4: A write to a shared line raises command 3 with the line address. The write completes only after the grant, and the line is dirty afterwards.
- R5: A write that misses raises command 2. After the grant the line is dirty and the write completes in the next cycle.
- R6: While a transaction waits, `bus_req` stays high and `cpu_ready` stays low until `bus_gnt`. At most one transaction is outstanding.
- R7: A snooped read (command 1) that hits a dirty line raises `snoop_flush` in that cycle with the line's data on `snoop_data`. The line becomes shared.
- R8: A snooped invalidate (3) or read with intent to modify (2) that hits a valid line makes it invalid. Command 2 hitting a dirty line also raises `snoop_flush` with the data.
- R9: A snoop whose tag differs from the one stored in the slot, or that hits an invalid slot, raises no flush and leaves the line unchanged.
- R10: A miss whose slot holds a dirty line of another tag first issues command 0, carrying the victim's address and data. It then issues the fetch.
- R11: A snooped invalidate of the line a pending write upgrade targets turns that pending request from command 3 into command 2.
- R12: `cpu_ready` is low in every cycle in which `snoop_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_cmd | output | 2 | Command of the pending transaction |
| bus_addr | output | ADDR_W | Address of the pending transaction |
| bus_wdata | output | DATA_W | Writeback data |
| bus_rdata | input | DATA_W | Fill data, valid with bus_gnt |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 2 | Its command |
| snoop_addr | input | ADDR_W | Its line address |
| snoop_flush | output | 1 | This cache supplies dirty data now |
| snoop_data | output | DATA_W | Supplied data |

## Verification
The hardest case to reach from the ports is a snooped invalidate that lands while the controller waits on its own upgrade of the same line. Without care, the granted invalidate would mark as dirty a line that no longer holds valid data. The bench reaches this case by issuing a write to a shared line, withholding the grant, and presenting a foreign invalidate of that line for one cycle. It then checks that the pending command has become a read with intent to modify before it grants the request. It also chains a dirty-victim writeback into the fetch that follows it, and it infers line states from the command that the next access produces.

// File: rtl/snoop_coherence_ctrl.sv
module snoop_coherence_ctrl #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_flush,
  output logic [DATA_W-1:0] snoop_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] CMD_WB = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_INV = 2'd3;

  typedef enum logic [1:0] {LN_INV = 2'd0, LN_SHR = 2'd1, LN_DRT = 2'd2} line_t;

  line_t             st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic              busy_q;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire c_match = (st_q[c_idx] != LN_INV) && (tag_q[c_idx] == c_tag);
  wire c_ok    = c_match && (!cpu_we || st_q[c_idx] == LN_DRT);
  wire victim_dirty = (st_q[c_idx] == LN_DRT) && (tag_q[c_idx] != c_tag);

  wire [IDX_W-1:0] s_idx = snoop_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snoop_addr[ADDR_W-1:IDX_W];
  wire s_match = (st_q[s_idx] != LN_INV) && (tag_q[s_idx] == s_tag);

  assign cpu_ready = cpu_req && !busy_q && !snoop_valid && c_ok;
  assign cpu_rdata = dat_q[c_idx];
  assign bus_req   = busy_q;
  assign bus_addr  = victim_dirty ? {tag_q[c_idx], c_idx} : cpu_addr;
  assign bus_wdata = dat_q[c_idx];

  always_comb begin
    if (victim_dirty)          bus_cmd = CMD_WB;
    else if (c_match && cpu_we) bus_cmd = CMD_INV;
    else if (cpu_we)            bus_cmd = CMD_RDX;
    else                        bus_cmd = CMD_RD;
  end

  assign snoop_flush = snoop_valid && s_match && (st_q[s_idx] == LN_DRT) &&
                       (snoop_cmd == CMD_RD || snoop_cmd == CMD_RDX);
  assign snoop_data  = dat_q[s_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LN_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (!busy_q && cpu_req && !snoop_valid && !c_ok) busy_q <= 1'b1;
      if (cpu_ready && cpu_we) dat_q[c_idx] <= cpu_wdata;
      if (snoop_valid && s_match) begin
        case (snoop_cmd)
          CMD_RD:  if (st_q[s_idx] == LN_DRT) st_q[s_idx] <= LN_SHR;
          CMD_RDX, CMD_INV: st_q[s_idx] <= LN_INV;
          default: ;
        endcase
      end
      if (busy_q && bus_gnt) begin
        case (bus_cmd)
          CMD_WB: st_q[c_idx] <= LN_INV;
          CMD_RD: begin
            st_q[c_idx] <= LN_SHR; tag_q[c_idx] <= c_tag;
            dat_q[c_idx] <= bus_rdata; busy_q <= 1'b0;
          end
          CMD_RDX: begin
            st_q[c_idx] <= LN_DRT; tag_q[c_idx] <= c_tag;
            dat_q[c_idx] <= bus_rdata; busy_q <= 1'b0;
          end
          default: begin
            st_q[c_idx] <= LN_DRT; busy_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);
  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_ready);
  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !bus_req);
  assert_flush_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_flush |-> snoop_valid && (snoop_cmd == CMD_RD || snoop_cmd == CMD_RDX));
  assert_snoop_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |-> !cpu_ready);
  assert_upgrade_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == CMD_INV |=> !bus_req);
  assert_wb_then_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == CMD_WB |=> bus_req);
endmodule

// File: tb/snoop_coherence_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_coherence_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, snoop_valid = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, bus_rdata = 0, snoop_addr = 0;
  logic [1:0] snoop_cmd = 0;
  logic [7:0] cpu_rdata, bus_addr, bus_wdata, snoop_data;
  logic [1:0] bus_cmd;
  logic cpu_ready, bus_req, snoop_flush;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  snoop_coherence_ctrl #(.LINES(4), .ADDR_W(8), .DATA_W(8)) dut_i (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_ready,
    .bus_req, .bus_gnt, .bus_cmd, .bus_addr, .bus_wdata, .bus_rdata,
    .snoop_valid, .snoop_cmd, .snoop_addr, .snoop_flush, .snoop_data);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic issue(input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic release_cpu();
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic serve(input logic [1:0] cmd, input logic [7:0] a, input logic [7:0] rd,
                       input logic [7:0] wd, input int hold, input string r);
    int guard = 0;
    while (!bus_req && guard < 20) begin @(negedge clk); #1; guard++; end
    chk(r, bus_req, 1);
    repeat (hold) begin
      @(negedge clk); #1;
      chk("R6 held", bus_req, 1);
      chk("R6 stall", cpu_ready, 0);
    end
    chk(r, bus_cmd, cmd);
    chk(r, bus_addr, a);
    if (cmd == 2'd0) chk(r, bus_wdata, wd);
    bus_gnt = 1; bus_rdata = rd;
    @(negedge clk); bus_gnt = 0; #1;
  endtask

  task automatic hit(input logic we, input logic [7:0] a, input logic [7:0] d,
                     input logic [7:0] exp_rd, input string r);
    issue(we, a, d); #1;
    chk(r, cpu_ready, 1);
    chk(r, bus_req, 0);
    if (!we) chk(r, cpu_rdata, exp_rd);
    release_cpu();
  endtask

  task automatic miss(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic [1:0] cmd, input logic [7:0] fill, input int hold, input string r);
    issue(we, a, d);
    serve(cmd, a, fill, 8'h00, hold, r);
    chk(r, cpu_ready, 1);
    if (!we) chk(r, cpu_rdata, fill);
    release_cpu();
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] a, input logic exp_fl,
                       input logic [7:0] exp_d, input string r);
    @(negedge clk);
    snoop_valid = 1; snoop_cmd = cmd; snoop_addr = a; #1;
    chk(r, snoop_flush, exp_fl);
    if (exp_fl) chk(r, snoop_data, exp_d);
    @(negedge clk); snoop_valid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 bus_req", bus_req, 0);
    chk("R1 flush", snoop_flush, 0);
    cpu_req = 1; cpu_addr = 8'h10; #0.1;
    chk("R1 no hit", cpu_ready, 0);
    cpu_req = 0;
  endtask

  task automatic t_read_miss();
    miss(0, 8'h10, 0, 2'd1, 8'hA5, 0, "R2 read miss");
    hit(0, 8'h10, 0, 8'hA5, "R2 shared read hit");
  endtask

  task automatic t_upgrade();
    miss(1, 8'h10, 8'h3C, 2'd3, 8'h00, 0, "R4 invalidate");
    hit(0, 8'h10, 0, 8'h3C, "R4 written data dirty read");
    hit(1, 8'h10, 8'h77, 0, "R3 dirty write hit");
    hit(0, 8'h10, 0, 8'h77, "R3 dirty read hit");
  endtask

  task automatic t_write_miss();
    miss(1, 8'h21, 8'h5A, 2'd2, 8'h00, 3, "R5 write miss");
    hit(0, 8'h21, 0, 8'h5A, "R5 line dirty after write");
  endtask

  task automatic t_snoops();
    snoop(2'd1, 8'h10, 1, 8'h77, "R7 read flush");
    miss(1, 8'h10, 8'h66, 2'd3, 8'h00, 0, "R7 line now shared");
    snoop(2'd2, 8'h21, 1, 8'h5A, "R8 rdx flush");
    miss(0, 8'h21, 0, 2'd1, 8'h5A, 0, "R8 rdx invalidated");
    snoop(2'd3, 8'h10, 0, 0, "R8 inv no flush");
    miss(0, 8'h10, 0, 2'd1, 8'hB1, 0, "R8 inv invalidated");
    snoop(2'd1, 8'h30, 0, 0, "R9 other tag");
    snoop(2'd3, 8'h30, 0, 0, "R9 other tag inv");
    snoop(2'd1, 8'h02, 0, 0, "R9 invalid slot");
    miss(1, 8'h10, 8'hC3, 2'd3, 8'h00, 0, "R9 line still shared");
  endtask

  task automatic t_evict();
    issue(0, 8'h14, 0);
    serve(2'd0, 8'h10, 8'h00, 8'hC3, 0, "R10 writeback");
    serve(2'd1, 8'h14, 8'h99, 8'h00, 0, "R10 fetch after writeback");
    chk("R10 ready", cpu_ready, 1);
    chk("R10 data", cpu_rdata, 8'h99);
    release_cpu();
  endtask

  task automatic t_race();
    issue(1, 8'h14, 8'h11);
    @(negedge clk); #1;
    chk("R11 pending upgrade", bus_cmd, 2'd3);
    snoop_valid = 1; snoop_cmd = 2'd3; snoop_addr = 8'h14;
    @(negedge clk); snoop_valid = 0; #1;
    chk("R11 turned rdx", bus_cmd, 2'd2);
    serve(2'd2, 8'h14, 8'h42, 8'h00, 0, "R11 rdx grant");
    chk("R11 ready", cpu_ready, 1);
    release_cpu();
    hit(0, 8'h14, 0, 8'h11, "R11 write landed");
  endtask

  task automatic t_snoop_stall();
    issue(0, 8'h14, 0);
    snoop_valid = 1; snoop_cmd = 2'd1; snoop_addr = 8'h33; #1;
    chk("R12 stalled", cpu_ready, 0);
    @(negedge clk); snoop_valid = 0; #1;
    chk("R12 resumes", cpu_ready, 1);
    chk("R12 data", cpu_rdata, 8'h11);
    release_cpu();
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_read_miss();
    t_upgrade();
    t_write_miss();
    t_snoops();
    t_evict();
    t_race();
    t_snoop_stall();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule